// File: doc/BRIEF.md
# Program Interrupt Classifier

This block takes one retiring-instruction event per strobe and decides which program-class interrupt, or which substitute interrupt, the event raises. The execute stage supplies the machine-state bits in force after the instruction (problem state and the two floating-point exception mode bits), the floating-point enabled-exception summary bit, and a set of flags that say what kind of instruction retired. The block returns a one-hot cause vector and a pending flag. Both are registered, and both hold until the interrupt logic acknowledges them.

Some architectural causes are redirected. An arithmetic floating-point instruction that leaves an enabled exception raises the floating-point assist interrupt, not the program interrupt. An illegal opcode raises the software-emulation interrupt, not the illegal-instruction program interrupt. The instruction-storage cause bit exists in the vector so that the vector has a fixed layout, but this logic never sets it. Decoding opcodes from raw instruction bits, and vectoring, are done elsewhere.

Top module: `pgm_irq_classifier`

## Requirements
- R1: While `rst` is high at a clock edge, `cause_q` becomes 0 and `pending` becomes 0 after that edge.
- R2: An event with `ev_valid` and any one of `is_mtfs`, `is_mtms` or `is_rfi` sets `cause_q` to 5'b00100 (bit 2, floating-point enabled program interrupt) after the next edge when `(fp_mode0 | fp_mode1) & fp_exc_sum` is 1.
- R3: An event flagged `is_fp_arith`, with `(fp_mode0 | fp_mode1) & fp_exc_sum` equal to 1, sets `cause_q` to 5'b01000 (bit 3, floating-point assist). It never sets bit 2.
- R4: An event flagged `is_illegal` always sets `cause_q` to 5'b00001 (bit 0, software emulation). This does not depend on the machine state.
- R5: An event with `is_spr_acc` set sets `cause_q` to 5'b00010 (bit 1, privileged) when `spr_field[SPR_W-1]` is 1 and `user_mode` is 1.
- R6: An event with `is_priv` set and `user_mode` at 1 sets `cause_q` to 5'b00010.
- R7: An event for which no condition holds loads 0 into `cause_q` and clears `pending`. No condition holds when the floating-point enable term is 0, or when `user_mode` is 0 for a privilege check, or when the SPR field's top bit is 0.
- R8: Bit 4 of `cause_q` (instruction storage) is never 1.
- R9: When several conditions hold together, only one cause is reported. The order of precedence is emulation (bit 0), then privileged (bit 1), then floating-point program (bit 2), then floating-point assist (bit 3).
- R10: A loaded cause is held until `ack`, and `ack` clears `cause_q` and `pending` at the next edge. If `ack` and `ev_valid` arrive in the same cycle, the new event is loaded.
- R11: `pending` is 1 exactly when `cause_q` is non-zero, and `cause_q` never has more than one bit set.
- R12: With neither `ev_valid` nor `ack`, `cause_q` and `pending` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | One retiring event is presented this cycle |
| ack | input | 1 | Interrupt taken; clear the held cause |
| user_mode | input | 1 | Problem-state bit |
| fp_mode0 | input | 1 | Floating-point exception mode bit 0 |
| fp_mode1 | input | 1 | Floating-point exception mode bit 1 |
| fp_exc_sum | input | 1 | Floating-point enabled-exception summary bit |
| is_mtfs | input | 1 | Event is a move to FP status register |
| is_mtms | input | 1 | Event is a move to machine state register |
| is_rfi | input | 1 | Event is a return from interrupt |
| is_fp_arith | input | 1 | Event is a floating-point arithmetic instruction |
| is_priv | input | 1 | Event is a privileged instruction |
| is_spr_acc | input | 1 | Event accesses a special-purpose register |
| spr_field | input | SPR_W | SPR number field of the access; the top bit marks privileged SPRs |
| is_illegal | input | 1 | Event is an illegal opcode |
| cause_q | output | 5 | One-hot cause: 0 emulation, 1 privileged, 2 FP program, 3 FP assist, 4 instruction storage |
| pending | output | 1 | A cause is held |

## Verification
The assertions assume that every input is a known value at each clock edge where `ev_valid` or `ack` is high, and that reset is applied at the start of the run. The properties that tie an event to its cause assume that the flags describe the same retiring instruction as the strobe. The bench drives all inputs at the falling edge from one task. That task returns every flag to zero after each strobe, so no flag left over from one event can reach the next. Several flags are set together only in the precedence scenarios.

// File: rtl/pgm_irq_pkg.sv
package pgm_irq_pkg;
  localparam int CAUSE_W   = 5;
  localparam int C_EMUL    = 0;
  localparam int C_PRIV    = 1;
  localparam int C_FP_PROG = 2;
  localparam int C_FP_ASST = 3;
  localparam int C_ISTOR   = 4;

  typedef struct packed {
    logic user_mode;
    logic fp_mode0;
    logic fp_mode1;
    logic fp_exc_sum;
    logic is_mtfs;
    logic is_mtms;
    logic is_rfi;
    logic is_fp_arith;
    logic is_priv;
    logic is_spr_acc;
    logic spr_top;
    logic is_illegal;
  } ev_flags_t;
endpackage

// File: rtl/pic_cond_eval.sv
module pic_cond_eval
  import pgm_irq_pkg::*;
(
  input  ev_flags_t          ev,
  output logic [CAUSE_W-1:0] raw
);
  logic fp_enabled;
  logic fp_state_op;
  logic priv_hit;

  always_comb begin
    fp_enabled  = (ev.fp_mode0 | ev.fp_mode1) & ev.fp_exc_sum;
    fp_state_op = ev.is_mtfs | ev.is_mtms | ev.is_rfi;
    priv_hit    = ev.user_mode & (ev.is_priv | (ev.is_spr_acc & ev.spr_top));
    raw            = '0;
    raw[C_EMUL]    = ev.is_illegal;
    raw[C_PRIV]    = priv_hit;
    raw[C_FP_PROG] = fp_enabled & fp_state_op;
    raw[C_FP_ASST] = fp_enabled & ev.is_fp_arith;
    raw[C_ISTOR]   = 1'b0;
  end
endmodule

// File: rtl/pic_prio_sel.sv
module pic_prio_sel #(
  parameter int W = 5
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] grant
);
  logic found;

  always_comb begin
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < W; i++) begin
      grant[i] = req[i] & ~found;
      found    = found | req[i];
    end
  end
endmodule

// File: rtl/pic_cause_reg.sv
module pic_cause_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      busy <= 1'b0;
    end else if (load) begin
      q    <= d;
      busy <= |d;
    end else if (clear) begin
      q    <= '0;
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/pgm_irq_classifier.sv
module pgm_irq_classifier
  import pgm_irq_pkg::*;
#(
  parameter int SPR_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic               ack,
  input  logic               user_mode,
  input  logic               fp_mode0,
  input  logic               fp_mode1,
  input  logic               fp_exc_sum,
  input  logic               is_mtfs,
  input  logic               is_mtms,
  input  logic               is_rfi,
  input  logic               is_fp_arith,
  input  logic               is_priv,
  input  logic               is_spr_acc,
  input  logic [SPR_W-1:0]   spr_field,
  input  logic               is_illegal,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               pending
);
  localparam int SPR_TOP = SPR_W - 1;

  ev_flags_t          ev;
  logic [CAUSE_W-1:0] raw;
  logic [CAUSE_W-1:0] picked;

  always_comb begin
    ev.user_mode   = user_mode;
    ev.fp_mode0    = fp_mode0;
    ev.fp_mode1    = fp_mode1;
    ev.fp_exc_sum  = fp_exc_sum;
    ev.is_mtfs     = is_mtfs;
    ev.is_mtms     = is_mtms;
    ev.is_rfi      = is_rfi;
    ev.is_fp_arith = is_fp_arith;
    ev.is_priv     = is_priv;
    ev.is_spr_acc  = is_spr_acc;
    ev.spr_top     = spr_field[SPR_TOP];
    ev.is_illegal  = is_illegal;
  end

  pic_cond_eval u_eval (
    .ev  (ev),
    .raw (raw)
  );

  pic_prio_sel #(.W(CAUSE_W)) u_prio (
    .req   (raw),
    .grant (picked)
  );

  pic_cause_reg #(.W(CAUSE_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .load  (ev_valid),
    .clear (ack),
    .d     (picked),
    .q     (cause_q),
    .busy  (pending)
  );
endmodule

// File: rtl/pgm_irq_classifier_chk.sv
module pgm_irq_classifier_chk #(
  parameter int SPR_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic             ack,
  input logic             user_mode,
  input logic             fp_mode0,
  input logic             fp_mode1,
  input logic             fp_exc_sum,
  input logic             is_mtfs,
  input logic             is_mtms,
  input logic             is_rfi,
  input logic             is_fp_arith,
  input logic             is_priv,
  input logic             is_spr_acc,
  input logic [SPR_W-1:0] spr_field,
  input logic             is_illegal,
  input logic [4:0]       cause_q,
  input logic             pending
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cause_q == 5'b0 && !pending));

  a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause_q));

  a_r11_pending_match: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> (pending == (cause_q != 5'b0)));

  a_r8_no_istor: assert property (@(posedge clk) disable iff (rst)
    !cause_q[4]);

  a_r4_emulation: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && is_illegal) |=> (cause_q == 5'b00001));

  a_r3_arith_not_prog: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && is_fp_arith && !is_mtfs && !is_mtms && !is_rfi) |=> !cause_q[2]);

  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !is_illegal && !user_mode && !fp_exc_sum) |=> (cause_q == 5'b0 && !pending));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !ev_valid) |=> (cause_q == 5'b0 && !pending));

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (!ack && !ev_valid) |=> ($stable(cause_q) && $stable(pending)));
endmodule

bind pgm_irq_classifier pgm_irq_classifier_chk #(.SPR_W(SPR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ev_valid    (ev_valid),
  .ack         (ack),
  .user_mode   (user_mode),
  .fp_mode0    (fp_mode0),
  .fp_mode1    (fp_mode1),
  .fp_exc_sum  (fp_exc_sum),
  .is_mtfs     (is_mtfs),
  .is_mtms     (is_mtms),
  .is_rfi      (is_rfi),
  .is_fp_arith (is_fp_arith),
  .is_priv     (is_priv),
  .is_spr_acc  (is_spr_acc),
  .spr_field   (spr_field),
  .is_illegal  (is_illegal),
  .cause_q     (cause_q),
  .pending     (pending)
);

// File: tb/pgm_irq_classifier_test.sv
module pgm_irq_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int SPR_W = 10;

  logic clk = 1'b0;
  logic rst, ev_valid, ack, user_mode, fp_mode0, fp_mode1, fp_exc_sum;
  logic is_mtfs, is_mtms, is_rfi, is_fp_arith, is_priv, is_spr_acc, is_illegal;
  logic [SPR_W-1:0] spr_field;
  logic [4:0] cause_q;
  logic pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgm_irq_classifier #(.SPR_W(SPR_W)) uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ack(ack),
    .user_mode(user_mode), .fp_mode0(fp_mode0), .fp_mode1(fp_mode1),
    .fp_exc_sum(fp_exc_sum), .is_mtfs(is_mtfs), .is_mtms(is_mtms),
    .is_rfi(is_rfi), .is_fp_arith(is_fp_arith), .is_priv(is_priv),
    .is_spr_acc(is_spr_acc), .spr_field(spr_field), .is_illegal(is_illegal),
    .cause_q(cause_q), .pending(pending)
  );

  task automatic clear_in();
    ev_valid = 0; ack = 0; user_mode = 0; fp_mode0 = 0; fp_mode1 = 0;
    fp_exc_sum = 0; is_mtfs = 0; is_mtms = 0; is_rfi = 0; is_fp_arith = 0;
    is_priv = 0; is_spr_acc = 0; is_illegal = 0; spr_field = '0;
  endtask

  task automatic expect_out(string req, logic [4:0] exp);
    checks++;
    if (cause_q !== exp || pending !== (exp != 5'b0)) begin
      errors++;
      $display("FAIL %s: cause=%b pending=%b expected cause=%b pending=%b",
               req, cause_q, pending, exp, (exp != 5'b0));
    end
  endtask

  // flags are set by the caller at a falling edge; strobe for one cycle
  task automatic strobe();
    ev_valid = 1;
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_ack();
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic t_reset();
    clear_in();
    rst = 1;
    repeat (2) @(negedge clk);
    expect_out("R1 reset", 5'b0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_fp_program();
    fp_mode0 = 1; fp_exc_sum = 1; is_mtfs = 1; strobe();
    expect_out("R2 mtfs", 5'b00100);
    fp_mode1 = 1; fp_exc_sum = 1; is_mtms = 1; strobe();
    expect_out("R2 mtms", 5'b00100);
    fp_mode0 = 1; fp_mode1 = 1; fp_exc_sum = 1; is_rfi = 1; strobe();
    expect_out("R2 rfi", 5'b00100);
    fp_mode0 = 0; fp_mode1 = 0; fp_exc_sum = 1; is_rfi = 1; strobe();
    expect_out("R7 rfi modes off", 5'b0);
  endtask

  task automatic t_fp_assist();
    fp_mode1 = 1; fp_exc_sum = 1; is_fp_arith = 1; strobe();
    expect_out("R3 arith assist", 5'b01000);
    fp_mode0 = 1; fp_exc_sum = 0; is_fp_arith = 1; strobe();
    expect_out("R7 arith no summary", 5'b0);
  endtask

  task automatic t_illegal();
    is_illegal = 1; strobe();
    expect_out("R4 illegal supervisor", 5'b00001);
    is_illegal = 1; user_mode = 1; fp_mode0 = 1; fp_exc_sum = 1; strobe();
    expect_out("R4 illegal user", 5'b00001);
  endtask

  task automatic t_privileged();
    user_mode = 1; is_spr_acc = 1; spr_field = 10'h200; strobe();
    expect_out("R5 spr top bit user", 5'b00010);
    user_mode = 1; is_spr_acc = 1; spr_field = 10'h1FF; strobe();
    expect_out("R7 spr top bit clear", 5'b0);
    user_mode = 0; is_spr_acc = 1; spr_field = 10'h3FF; strobe();
    expect_out("R7 spr supervisor", 5'b0);
    user_mode = 1; is_priv = 1; strobe();
    expect_out("R6 priv user", 5'b00010);
    user_mode = 0; is_priv = 1; strobe();
    expect_out("R7 priv supervisor", 5'b0);
  endtask

  task automatic t_priority();
    is_illegal = 1; user_mode = 1; is_priv = 1; strobe();
    expect_out("R9 emul over priv", 5'b00001);
    user_mode = 1; is_priv = 1; fp_mode0 = 1; fp_exc_sum = 1; is_mtms = 1; strobe();
    expect_out("R9 priv over fp", 5'b00010);
    fp_mode0 = 1; fp_exc_sum = 1; is_mtfs = 1; is_fp_arith = 1; strobe();
    expect_out("R9 prog over assist", 5'b00100);
  endtask

  task automatic t_hold_ack();
    user_mode = 1; is_priv = 1; strobe();
    expect_out("R10 loaded", 5'b00010);
    is_illegal = 1; user_mode = 1; fp_exc_sum = 1; fp_mode0 = 1; is_mtfs = 1;
    repeat (3) @(negedge clk);
    expect_out("R12 hold no strobe", 5'b00010);
    clear_in();
    do_ack();
    expect_out("R10 ack clears", 5'b0);
    fp_mode0 = 1; fp_exc_sum = 1; is_fp_arith = 1; strobe();
    expect_out("R11 assist loaded", 5'b01000);
    is_illegal = 1; ack = 1; strobe();
    expect_out("R10 strobe beats ack", 5'b00001);
    do_ack();
    expect_out("R8 R11 idle after ack", 5'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1;
    @(negedge clk);
    t_reset();
    t_fp_program();
    t_fp_assist();
    t_illegal();
    t_privileged();
    t_priority();
    t_hold_ack();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule